// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic unit of an 8-bit accumulator machine. Each cycle in which `op_valid` is high, it takes the accumulator byte, a second operand byte, the multiplier/divisor byte, and the incoming carry, auxiliary-carry and overflow flags. It then registers a primary result that replaces the accumulator, a secondary result byte, and the updated flags. The core around it fetches operands in any addressing mode and writes the results back. This unit does not fetch operands and does not store flags.

The operation set covers the following. Binary add with and without carry-in. Subtract with borrow. Increment and decrement. An unsigned 8x8 multiply with a 16-bit product. Unsigned divide giving quotient and remainder. A decimal-adjust step for packed BCD after an addition. Bitwise AND, OR and XOR. Clear and complement. Nibble swap. Rotation left and right, each either plain or through the carry.

Top module: `acc_alu`

## Requirements
- R1: Results appear one clock after the cycle in which `op_valid` is high, and `res_valid` is high for exactly that one cycle. While reset is active, all outputs are zero.
- R2: The opcode encoding is: 0 add, 1 add-with-carry, 2 subtract-with-borrow, 3 increment, 4 decrement, 5 multiply, 6 divide, 7 decimal adjust, 8 AND, 9 OR, 10 XOR, 11 clear, 12 complement, 13 swap, 14 rotate left, 15 rotate left through carry, 16 rotate right, 17 rotate right through carry. Any other code returns the accumulator and the flags unchanged.
- R3: Add gives A+operand, and add-with-carry gives A+operand+C. Carry is the bit-7 carry-out. Auxiliary carry is the bit-3 carry-out. Overflow is set when the two inputs have the same sign and the result sign differs from it.
- R4: Subtract-with-borrow gives A-operand-C. Carry is set on borrow out of bit 7. Auxiliary carry is set on borrow out of bit 3. Overflow is set when the input signs differ and the result sign differs from the sign of A.
- R5: Multiply puts the product A*B with its low byte on `res_a` and its high byte on `res_b`. Carry is cleared. Overflow is set exactly when the product exceeds 255.
- R6: Divide puts the quotient A/B on `res_a` and the remainder on `res_b`, and clears carry. With B equal to zero, overflow is set and both result bytes are undefined. Otherwise overflow is cleared.
- R7: Increment and decrement wrap modulo 256 and leave all flags unchanged.
- R8: Decimal adjust first adds 06h when the low nibble is above 9 or auxiliary carry is set. It then adds 60h when the resulting high nibble is above 9 or carry (incoming or from the first step) is set. Carry out is the OR of the incoming carry, the first-step carry and the second-step condition.
- R9: AND, OR, XOR, clear, complement and swap act on A alone or on A with the operand, and leave all flags unchanged. Swap exchanges A[3:0] with A[7:4].
- R10: Plain rotates move A7 to A0 (left) or A0 to A7 (right), and keep the carry. Rotates through carry load C into the vacated bit and the bit shifted out into C.
- R11: For every operation except multiply and divide, `res_b` equals `breg_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request this cycle |
| op_code | input | 5 | Operation select (R2) |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand byte |
| breg_in | input | 8 | B register value |
| cy_in | input | 1 | Carry flag in |
| ac_in | input | 1 | Auxiliary carry flag in |
| ov_in | input | 1 | Overflow flag in |
| res_valid | output | 1 | Results valid |
| res_a | output | 8 | Result replacing the accumulator |
| res_b | output | 8 | Result for the B register |
| cy_out | output | 1 | Carry flag out |
| ac_out | output | 1 | Auxiliary carry flag out |
| ov_out | output | 1 | Overflow flag out |

## Verification
Every operation, including multiply and divide, is due on the outputs exactly one clock edge after its request. The driver applies a request on a falling edge and queues the expected bytes and flags at that moment. The monitor pops one item on each later falling edge where `res_valid` is high, so each comparison lands half a cycle after the register update. Division by zero is compared on the flags only. A check at the end confirms that no queued item was left without a result.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [4:0] op_code,
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd_in,
  input  logic [7:0] breg_in,
  input  logic       cy_in,
  input  logic       ac_in,
  input  logic       ov_in,
  output logic       res_valid,
  output logic [7:0] res_a,
  output logic [7:0] res_b,
  output logic       cy_out,
  output logic       ac_out,
  output logic       ov_out
);
  localparam logic [4:0] OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUBB = 5'd2,
                         OP_INC  = 5'd3,  OP_DEC  = 5'd4,  OP_MUL  = 5'd5,
                         OP_DIV  = 5'd6,  OP_DA   = 5'd7,  OP_AND  = 5'd8,
                         OP_OR   = 5'd9,  OP_XOR  = 5'd10, OP_CLR  = 5'd11,
                         OP_CPL  = 5'd12, OP_SWAP = 5'd13, OP_RL   = 5'd14,
                         OP_RLC  = 5'd15, OP_RR   = 5'd16, OP_RRC  = 5'd17;

  logic       cin;
  logic [8:0] sum9, dif9, t9, u9;
  logic [4:0] slo, dlo;
  logic [15:0] prod;
  logic       lo_fix, hi_fix, cyt;
  logic [7:0] n_a, n_b;
  logic       n_cy, n_ac, n_ov;

  assign cin  = (op_code == OP_ADDC) ? cy_in : 1'b0;
  assign sum9 = {1'b0, acc_in} + {1'b0, opnd_in} + {8'd0, cin};
  assign slo  = {1'b0, acc_in[3:0]} + {1'b0, opnd_in[3:0]} + {4'd0, cin};
  assign dif9 = {1'b0, acc_in} - {1'b0, opnd_in} - {8'd0, cy_in};
  assign dlo  = {1'b0, acc_in[3:0]} - {1'b0, opnd_in[3:0]} - {4'd0, cy_in};
  assign prod = {8'd0, acc_in} * {8'd0, breg_in};

  assign lo_fix = (acc_in[3:0] > 4'd9) || ac_in;
  assign t9     = {1'b0, acc_in} + (lo_fix ? 9'h006 : 9'h000);
  assign cyt    = cy_in | t9[8];
  assign hi_fix = (t9[7:4] > 4'd9) || cyt;
  assign u9     = {1'b0, t9[7:0]} + (hi_fix ? 9'h060 : 9'h000);

  always_comb begin
    n_a  = acc_in;
    n_b  = breg_in;
    n_cy = cy_in;
    n_ac = ac_in;
    n_ov = ov_in;
    case (op_code)
      OP_ADD, OP_ADDC: begin
        n_a  = sum9[7:0];
        n_cy = sum9[8];
        n_ac = slo[4];
        n_ov = (acc_in[7] == opnd_in[7]) && (sum9[7] != acc_in[7]);
      end
      OP_SUBB: begin
        n_a  = dif9[7:0];
        n_cy = dif9[8];
        n_ac = dlo[4];
        n_ov = (acc_in[7] != opnd_in[7]) && (dif9[7] != acc_in[7]);
      end
      OP_INC:  n_a = acc_in + 8'd1;
      OP_DEC:  n_a = acc_in - 8'd1;
      OP_MUL: begin
        n_a  = prod[7:0];
        n_b  = prod[15:8];
        n_cy = 1'b0;
        n_ov = |prod[15:8];
      end
      OP_DIV: begin
        n_cy = 1'b0;
        if (breg_in == 8'd0) begin
          n_a  = 8'hFF;
          n_b  = acc_in;
          n_ov = 1'b1;
        end else begin
          n_a  = acc_in / breg_in;
          n_b  = acc_in % breg_in;
          n_ov = 1'b0;
        end
      end
      OP_DA: begin
        n_a  = u9[7:0];
        n_cy = cyt | hi_fix;
      end
      OP_AND:  n_a = acc_in & opnd_in;
      OP_OR:   n_a = acc_in | opnd_in;
      OP_XOR:  n_a = acc_in ^ opnd_in;
      OP_CLR:  n_a = 8'd0;
      OP_CPL:  n_a = ~acc_in;
      OP_SWAP: n_a = {acc_in[3:0], acc_in[7:4]};
      OP_RL:   n_a = {acc_in[6:0], acc_in[7]};
      OP_RR:   n_a = {acc_in[0], acc_in[7:1]};
      OP_RLC: begin
        n_a  = {acc_in[6:0], cy_in};
        n_cy = acc_in[7];
      end
      OP_RRC: begin
        n_a  = {cy_in, acc_in[7:1]};
        n_cy = acc_in[0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_a     <= 8'd0;
      res_b     <= 8'd0;
      cy_out    <= 1'b0;
      ac_out    <= 1'b0;
      ov_out    <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_a  <= n_a;
        res_b  <= n_b;
        cy_out <= n_cy;
        ac_out <= n_ac;
        ov_out <= n_ov;
      end
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid); // R1
  AST_MUL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_MUL) |=> (!cy_out && (ov_out == (res_b != 8'd0)))); // R5
  AST_DIV_CY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_DIV) |=> !cy_out); // R6
  AST_DIV_ZERO_OV: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_DIV && breg_in == 8'd0) |=> ov_out); // R6
  AST_INC_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_INC || op_code == OP_DEC)) |=>
      (cy_out == $past(cy_in) && ac_out == $past(ac_in) && ov_out == $past(ov_in))); // R7
  AST_SWAP_NIBBLES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SWAP) |=>
      (res_a[7:4] == $past(acc_in[3:0]) && res_a[3:0] == $past(acc_in[7:4]))); // R9
  AST_RLC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_RLC) |=> (cy_out == $past(acc_in[7]) && res_a[0] == $past(cy_in))); // R10
  AST_B_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code != OP_MUL && op_code != OP_DIV) |=> res_b == $past(breg_in)); // R11
endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, op_valid, cy_in, ac_in, ov_in;
  logic [4:0] op_code;
  logic [7:0] acc_in, opnd_in, breg_in;
  logic       res_valid, cy_out, ac_out, ov_out;
  logic [7:0] res_a, res_b;

  acc_alu uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .breg_in(breg_in), .cy_in(cy_in),
    .ac_in(ac_in), .ov_in(ov_in), .res_valid(res_valid), .res_a(res_a),
    .res_b(res_b), .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out));

  typedef struct packed {
    logic       flags_only;
    logic [4:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic       cy, ac, ov;
  } item_t;

  item_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic string req_of(input logic [4:0] op);
    case (op)
      5'd0, 5'd1: return "R3";
      5'd2: return "R4";
      5'd3, 5'd4: return "R7";
      5'd5: return "R5";
      5'd6: return "R6";
      5'd7: return "R8";
      5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13: return "R9";
      5'd14, 5'd15, 5'd16, 5'd17: return "R10";
      default: return "R2";
    endcase
  endfunction

  function automatic item_t model(input logic [4:0] op, input logic [7:0] a,
      input logic [7:0] x, input logic [7:0] b, input logic c, input logic h, input logic v);
    item_t e;
    int s, lo;
    e = '{flags_only: 1'b0, op: op, a: a, b: b, cy: c, ac: h, ov: v};
    case (op)
      5'd0, 5'd1: begin
        s  = int'(a) + int'(x) + ((op == 5'd1) ? int'(c) : 0);
        lo = int'(a[3:0]) + int'(x[3:0]) + ((op == 5'd1) ? int'(c) : 0);
        e.a = s[7:0]; e.cy = (s > 255); e.ac = (lo > 15);
        e.ov = (s[7:0] >= 8'h80) != (a >= 8'h80) && ((a >= 8'h80) == (x >= 8'h80));
      end
      5'd2: begin
        s  = int'(a) - int'(x) - int'(c);
        lo = int'(a[3:0]) - int'(x[3:0]) - int'(c);
        e.a = s[7:0]; e.cy = (s < 0); e.ac = (lo < 0);
        e.ov = ((a >= 8'h80) != (x >= 8'h80)) && ((s[7:0] >= 8'h80) != (a >= 8'h80));
      end
      5'd3: e.a = 8'((int'(a) + 1) % 256);
      5'd4: e.a = 8'((int'(a) + 255) % 256);
      5'd5: begin
        s = int'(a) * int'(b);
        e.a = s[7:0]; e.b = s[15:8]; e.cy = 1'b0; e.ov = (s > 255);
      end
      5'd6: begin
        e.cy = 1'b0;
        if (b == 0) begin e.ov = 1'b1; e.flags_only = 1'b1; end
        else begin e.a = 8'(int'(a) / int'(b)); e.b = 8'(int'(a) % int'(b)); e.ov = 1'b0; end
      end
      5'd7: begin
        s = int'(a);
        if (int'(a[3:0]) > 9 || h) s = s + 6;
        if (s > 255) e.cy = 1'b1;
        if (((s / 16) % 16) > 9 || e.cy) begin s = (s % 256) + 96; e.cy = 1'b1; end
        e.a = s[7:0];
      end
      5'd8:  e.a = a & x;
      5'd9:  e.a = a | x;
      5'd10: e.a = a ^ x;
      5'd11: e.a = 8'h00;
      5'd12: e.a = 8'hFF - a;
      5'd13: e.a = {a[3:0], a[7:4]};
      5'd14: e.a = {a[6:0], a[7]};
      5'd15: begin e.a = {a[6:0], c}; e.cy = a[7]; end
      5'd16: e.a = {a[0], a[7:1]};
      5'd17: begin e.a = {c, a[7:1]}; e.cy = a[0]; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [4:0] op, input logic [7:0] a, input logic [7:0] x,
      input logic [7:0] b, input logic c, input logic h, input logic v);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; acc_in = a; opnd_in = x; breg_in = b;
    cy_in = c; ac_in = h; ov_in = v;
    sb.push_back(model(op, a, x, b, c, h, v));
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin : monitor
    item_t e;
    forever begin
      @(negedge clk);
      if (rst_n && res_valid) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R1 unexpected res_valid got=1 exp=0");
        end else begin
          e = sb.pop_front();
          if (e.flags_only ? (cy_out !== e.cy || ov_out !== e.ov)
              : (res_a !== e.a || res_b !== e.b || cy_out !== e.cy ||
                 ac_out !== e.ac || ov_out !== e.ov)) begin
            errors++;
            $display("FAIL %s op=%0d got a=%h b=%h c=%b ac=%b ov=%b exp a=%h b=%h c=%b ac=%b ov=%b",
              req_of(e.op), e.op, res_a, res_b, cy_out, ac_out, ov_out,
              e.a, e.b, e.cy, e.ac, e.ov);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired got=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; acc_in = '0; opnd_in = '0;
    breg_in = '0; cy_in = 0; ac_in = 0; ov_in = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 0 || res_a !== 0 || res_b !== 0 || cy_out !== 0 || ac_out !== 0 || ov_out !== 0) begin
      errors++;
      $display("FAIL R1 reset state got v=%b a=%h b=%h exp all zero", res_valid, res_a, res_b);
    end
    rst_n = 1'b1;
    // R3
    drive(5'd0, 8'h7F, 8'h01, 8'h11, 0, 0, 0);
    drive(5'd0, 8'hFF, 8'h01, 8'h22, 0, 0, 0);
    drive(5'd1, 8'h10, 8'h20, 8'h33, 1, 0, 1);
    drive(5'd1, 8'h80, 8'h80, 8'h44, 1, 1, 0);
    // R4
    drive(5'd2, 8'h05, 8'h06, 8'h00, 0, 0, 0);
    drive(5'd2, 8'h80, 8'h01, 8'h00, 0, 0, 0);
    drive(5'd2, 8'h50, 8'h20, 8'h00, 1, 1, 1);
    // R7
    drive(5'd3, 8'hFF, 8'h00, 8'h55, 1, 1, 1);
    drive(5'd4, 8'h00, 8'h00, 8'h66, 0, 1, 0);
    // R5
    drive(5'd5, 8'h20, 8'h00, 8'h10, 1, 0, 0);
    drive(5'd5, 8'h03, 8'h00, 8'h04, 1, 1, 1);
    drive(5'd5, 8'hFF, 8'h00, 8'hFF, 0, 0, 0);
    // R6
    drive(5'd6, 8'h64, 8'h00, 8'h07, 1, 0, 1);
    drive(5'd6, 8'h05, 8'h00, 8'h09, 1, 0, 0);
    drive(5'd6, 8'h33, 8'h00, 8'h00, 1, 0, 0);
    idle();
    // R8
    drive(5'd7, 8'h1A, 8'h00, 8'h00, 0, 0, 0);
    drive(5'd7, 8'h9A, 8'h00, 8'h00, 0, 0, 0);
    drive(5'd7, 8'h23, 8'h00, 8'h00, 0, 1, 0);
    drive(5'd7, 8'h45, 8'h00, 8'h00, 1, 0, 0);
    drive(5'd7, 8'h99, 8'h00, 8'h00, 0, 0, 0);
    // R9
    drive(5'd8, 8'hF0, 8'h3C, 8'h01, 1, 0, 1);
    drive(5'd9, 8'hA0, 8'h05, 8'h02, 0, 1, 0);
    drive(5'd10, 8'hFF, 8'h0F, 8'h03, 1, 1, 1);
    drive(5'd11, 8'h5A, 8'h00, 8'h04, 0, 0, 0);
    drive(5'd12, 8'h5A, 8'h00, 8'h05, 1, 0, 0);
    drive(5'd13, 8'h3C, 8'h00, 8'h06, 0, 0, 1);
    // R10
    drive(5'd14, 8'h81, 8'h00, 8'h07, 0, 0, 0);
    drive(5'd15, 8'h81, 8'h00, 8'h08, 0, 0, 0);
    drive(5'd16, 8'h81, 8'h00, 8'h09, 1, 0, 0);
    drive(5'd17, 8'h80, 8'h00, 8'h0A, 1, 0, 0);
    // R2 unused code, R11 covered by res_b in all above
    drive(5'd25, 8'hC3, 8'h12, 8'hBE, 1, 0, 1);
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0 || res_valid !== 0) begin
      errors++;
      $display("FAIL R1 pending results got=%0d exp=0", sb.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule